// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

A single-port synchronous memory whose every control input, address and write word is captured on the rising clock edge, with a registered read path that delivers data one clock after the read is taken. Each word is four 9-bit byte lanes (36 bits). The depth is a parameter kept small for simulation. Two address strobes start accesses with different write rules. A step input then walks a four-beat burst in linear or interleaved order, or holds the current address as a wait state. Three chip-select inputs must all agree before a strobe opens an access.

The output side carries no pad model. `rdata_oe` is the drive enable that a pad ring would use, and `rdata` reads zero whenever that enable is low. The output-enable input acts on the drive without waiting for a clock. Data moves as plain synchronous strobes rather than a valid/ready stream, because a burst memory cannot stall, so the edge of the block has no back-pressure. A host that is not ready holds the burst with the step input. The burst order is chosen by a static strap input.

Top module: `burst_sram_core`

## Requirements
- R1: The chip counts as selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1 in the same cycle. A strobe cycle with any other combination ends the burst, and `rdata_oe` is 0 within two clocks of it.
- R2: While `sel_a_n`=1 the processor strobe `strobe_proc_n` is ignored. In that state `strobe_ctl_n`=0 is a deselect, and with `strobe_ctl_n`=1 the cycle behaves as a burst-continue or burst-suspend cycle.
- R3: `strobe_proc_n`=0 with the chip selected loads the address and starts a read in that cycle, and no lane is written in that cycle whatever the write inputs show. A write to that address needs a later cycle that carries a write command.
- R4: With `strobe_proc_n` not taking effect, `strobe_ctl_n`=0 and the chip selected loads the address. The cycle writes if the write command is active and reads otherwise.
- R5: The write command is active when `all_lanes_wr_n`=0, and then all four lanes are written. It is also active when `all_lanes_wr_n`=1, `lane_wr_en_n`=0 and some bit i of `lane_sel_n` is 0, and then only those lanes are written. Lane i is data bits 9i+8 down to 9i, so lane 0 is bits 8:0 and lane 3 is bits 35:27. With no active write command the cycle is a read.
- R6: With both strobes high during a live burst, `burst_step_n`=0 moves to the next address. Only the two low address bits change, and they wrap after four beats. Linear order (`linear_burst`=1) gives start+n mod 4. Interleaved order (`linear_burst`=0) gives start XOR n.
- R7: With both strobes high during a live burst, `burst_step_n`=1 repeats the current address. A read is repeated, and a write with a write command goes to the same address.
- R8: A read sampled at edge k drives its word on `rdata` with `rdata_oe`=1 from edge k+1 until edge k+2, provided `out_en_n`=0 and no write is sampled at edge k+1. Every read sampled under those conditions produces exactly one such word.
- R9: `out_en_n`=1 turns `rdata_oe` off and forces `rdata` to zero at once, without waiting for a clock edge. Setting it back to 0 restores the pending word.
- R10: A write sampled at edge k keeps `rdata_oe` at 0 from edge k until edge k+1, even when a read word is pending. Output stays off after a write until a later read.
- R11: Reset (`rst_n`=0, asynchronous) turns the output off and leaves no live burst. Continue or suspend cycles before the first strobe-started access neither read nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, sampled on a strobe |
| strobe_proc_n | input | 1 | Processor address strobe, active low, always reads |
| strobe_ctl_n | input | 1 | Controller address strobe, active low, reads or writes |
| burst_step_n | input | 1 | Active low: advance the burst address |
| sel_a_n | input | 1 | Chip select, active low, also gates the processor strobe |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| all_lanes_wr_n | input | 1 | Active low: write all lanes |
| lane_wr_en_n | input | 1 | Active low: enable the per-lane write selects |
| lane_sel_n | input | LANES | Per-lane write select, active low, bit i is lane i |
| linear_burst | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write word, sampled with the write command |
| rdata | output | LANES*LANE_W | Read word, zero when not driven |
| rdata_oe | output | 1 | Read drive enable |

## Verification
If the burst counter or the stored base address goes wrong, the effect shows up one clock after the next read is taken. The word on `rdata` then belongs to a neighbouring lane group or address, and a lane-by-lane comparison against a reference array catches it. A lost lane-mask bit or a write taken on a processor-strobe cycle shows up only when that address is read again. The bench therefore reads back every address it has touched. A stuck valid or write stage shows up as a drive enable that lingers for a clock after a deselect or write, or as an extra or missing word in the scoreboard queue.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // decoded intent of one sampled clock edge
  typedef struct packed {
    logic load;     // take the external address as burst base
    logic advance;  // step to the next burst beat
    logic rd;       // a read is performed at the effective address
    logic wr;       // a write is performed at the effective address
    logic desel;    // the burst ends and output must turn off
  } sram_cmd_t;

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             strobe_proc_n,
  input  logic             strobe_ctl_n,
  input  logic             burst_step_n,
  input  logic             sel_a_n,
  input  logic             sel_b_n,
  input  logic             sel_c,
  input  logic             all_lanes_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             burst_live,
  output sram_cmd_t        cmd,
  output logic [LANES-1:0] wmask
);

  logic             chip_on;
  logic             proc_path;
  logic [LANES-1:0] req_mask;
  logic             wr_req;

  always_comb begin
    chip_on   = !sel_a_n && !sel_b_n && sel_c;
    // the processor strobe only counts while the first select is active
    proc_path = !strobe_proc_n && !sel_a_n;
    if (!all_lanes_wr_n)    req_mask = '1;
    else if (!lane_wr_en_n) req_mask = ~lane_sel_n;
    else                    req_mask = '0;
    wr_req = |req_mask;
  end

  always_comb begin
    cmd   = '0;
    wmask = '0;
    if (proc_path) begin
      // processor strobe: always a read, write inputs ignored this edge
      if (chip_on) begin
        cmd.load = 1'b1;
        cmd.rd   = 1'b1;
      end else begin
        cmd.desel = 1'b1;
      end
    end else if (!strobe_ctl_n) begin
      if (chip_on) begin
        cmd.load = 1'b1;
        if (wr_req) begin
          cmd.wr = 1'b1;
          wmask  = req_mask;
        end else begin
          cmd.rd = 1'b1;
        end
      end else begin
        cmd.desel = 1'b1;
      end
    end else if (burst_live) begin
      cmd.advance = !burst_step_n;
      if (wr_req) begin
        cmd.wr = 1'b1;
        wmask  = req_mask;
      end else begin
        cmd.rd = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sram_burst_gen.sv
module sram_burst_gen #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              desel,
  input  logic              linear_burst,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              burst_live
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic [HI_W-1:0]    base_hi_q;
  logic [BURST_W-1:0] start_lo_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] beat_nxt;
  logic [BURST_W-1:0] lo_cur;
  logic [BURST_W-1:0] lo_nxt;

  always_comb begin
    beat_nxt = beat_q + 1'b1;
    if (linear_burst) begin
      lo_cur = start_lo_q + beat_q;
      lo_nxt = start_lo_q + beat_nxt;
    end else begin
      lo_cur = start_lo_q ^ beat_q;
      lo_nxt = start_lo_q ^ beat_nxt;
    end
    cur_addr = {base_hi_q, lo_cur};
    nxt_addr = {base_hi_q, lo_nxt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_hi_q  <= '0;
      start_lo_q <= '0;
      beat_q     <= '0;
      burst_live <= 1'b0;
    end else if (load) begin
      base_hi_q  <= ld_addr[ADDR_W-1:BURST_W];
      start_lo_q <= ld_addr[BURST_W-1:0];
      beat_q     <= '0;
      burst_live <= 1'b1;
    end else if (desel) begin
      burst_live <= 1'b0;
    end else if (advance) begin
      beat_q <= beat_nxt;
    end
  end

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [LANE_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // output register: reads the address latched one edge earlier
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wd;
    q <= mem[rd_addr];
  end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 9,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strobe_proc_n,
  input  logic                    strobe_ctl_n,
  input  logic                    burst_step_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic                    all_lanes_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    linear_burst,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int WORD_W = LANES * LANE_W;

  sram_cmd_t         cmd;
  logic [LANES-1:0]  wmask;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic              burst_live;

  logic              rd_pend_q;
  logic              wr_q;
  logic              dvalid_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [WORD_W-1:0] q_word;

  sram_cmd_decode #(.LANES(LANES)) u_dec (
    .strobe_proc_n  (strobe_proc_n),
    .strobe_ctl_n   (strobe_ctl_n),
    .burst_step_n   (burst_step_n),
    .sel_a_n        (sel_a_n),
    .sel_b_n        (sel_b_n),
    .sel_c          (sel_c),
    .all_lanes_wr_n (all_lanes_wr_n),
    .lane_wr_en_n   (lane_wr_en_n),
    .lane_sel_n     (lane_sel_n),
    .burst_live     (burst_live),
    .cmd            (cmd),
    .wmask          (wmask)
  );

  sram_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (cmd.load),
    .advance      (cmd.advance),
    .desel        (cmd.desel),
    .linear_burst (linear_burst),
    .ld_addr      (addr),
    .cur_addr     (cur_addr),
    .nxt_addr     (nxt_addr),
    .burst_live   (burst_live)
  );

  always_comb begin
    if (cmd.load)         eff_addr = addr;
    else if (cmd.advance) eff_addr = nxt_addr;
    else                  eff_addr = cur_addr;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk     (clk),
      .we      (cmd.wr && wmask[g]),
      .waddr   (eff_addr),
      .wd      (wdata[g*LANE_W +: LANE_W]),
      .rd_addr (rd_addr_q),
      .q       (q_word[g*LANE_W +: LANE_W])
    );
  end

  // stage 1 holds the sampled access, stage 2 marks the output word valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      wr_q      <= 1'b0;
      dvalid_q  <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_pend_q <= cmd.rd;
      wr_q      <= cmd.wr;
      dvalid_q  <= rd_pend_q;
      if (cmd.rd) rd_addr_q <= eff_addr;
    end
  end

  assign rdata_oe = dvalid_q && !wr_q && !out_en_n;
  assign rdata    = rdata_oe ? q_word : '0;

endmodule

// File: rtl/burst_sram_core_chk.sv
module burst_sram_core_chk #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              strobe_proc_n,
  input logic              strobe_ctl_n,
  input logic              burst_step_n,
  input logic              sel_a_n,
  input logic              sel_b_n,
  input logic              sel_c,
  input logic              all_lanes_wr_n,
  input logic              lane_wr_en_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic              out_en_n,
  input logic              rdata_oe,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              burst_live
);

  logic chip_on, proc_take, ctl_take, desel_cyc, wr_strobe, cont_cyc;

  always_comb begin
    chip_on   = !sel_a_n && !sel_b_n && sel_c;
    proc_take = !strobe_proc_n && !sel_a_n;
    ctl_take  = !proc_take && !strobe_ctl_n;
    desel_cyc = (proc_take || ctl_take) && !chip_on;
    wr_strobe = !all_lanes_wr_n || (!lane_wr_en_n && !(&lane_sel_n));
    cont_cyc  = !proc_take && strobe_ctl_n && burst_live;
  end

  // R1: deselect turns the drive off within two clocks
  p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
    desel_cyc |=> ##1 !rdata_oe);

  // R4: a strobe-started access loads the sampled address as current beat
  p_load_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_take || ctl_take) && chip_on) |=> (cur_addr == $past(addr)));

  // R6: stepping changes only the low beat bits
  p_step_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_cyc && !burst_step_n) |=>
      ((cur_addr != $past(cur_addr)) &&
       (cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]))));

  // R7: suspend holds the current beat
  p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_cyc && burst_step_n) |=> $stable(cur_addr));

  // R8: a processor-strobe read not followed by a write is driven a clock later
  p_read_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_take && chip_on) ##1 !wr_strobe) |=> (out_en_n || rdata_oe));

  // R10: a write taken by the controller strobe keeps the drive off
  p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_take && chip_on && wr_strobe) |=> !rdata_oe);

endmodule

bind burst_sram_core burst_sram_core_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .addr           (addr),
  .strobe_proc_n  (strobe_proc_n),
  .strobe_ctl_n   (strobe_ctl_n),
  .burst_step_n   (burst_step_n),
  .sel_a_n        (sel_a_n),
  .sel_b_n        (sel_b_n),
  .sel_c          (sel_c),
  .all_lanes_wr_n (all_lanes_wr_n),
  .lane_wr_en_n   (lane_wr_en_n),
  .lane_sel_n     (lane_sel_n),
  .out_en_n       (out_en_n),
  .rdata_oe       (rdata_oe),
  .cur_addr       (cur_addr),
  .burst_live     (burst_live)
);

// File: tb/burst_sram_core_tb.sv
`timescale 1ns/1ps
module burst_sram_core_tb;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int WW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          p_n = 1'b1, c_n = 1'b1, st_n = 1'b1;
  logic          sa_n = 1'b1, sb_n = 1'b0, sc = 1'b1;
  logic          gw_n = 1'b1, be_n = 1'b1;
  logic [LN-1:0] ls_n = '1;
  logic          lin = 1'b0, oe_n = 1'b0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          rdata_oe;

  burst_sram_core u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .strobe_proc_n(p_n), .strobe_ctl_n(c_n), .burst_step_n(st_n),
    .sel_a_n(sa_n), .sel_b_n(sb_n), .sel_c(sc),
    .all_lanes_wr_n(gw_n), .lane_wr_en_n(be_n), .lane_sel_n(ls_n),
    .linear_burst(lin), .out_en_n(oe_n), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int checks = 0;
  int bad = 0;
  bit done = 0;

  typedef struct { logic [WW-1:0] v; string tag; } exp_t;
  exp_t exp_q[$];

  // reference model built from the requirements
  logic [WW-1:0] rmem [DEPTH];
  bit            m_live = 0;
  logic [AW-1:0] m_base = '0;
  int            m_cnt = 0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] s, n;
    s = m_base[1:0];
    n = 2'(m_cnt);
    return {m_base[AW-1:2], (lin ? 2'(s + n) : (s ^ n))};
  endfunction

  function automatic logic [WW-1:0] pat(int a);
    return {9'(a * 7 + 1), 9'(a * 5 + 2), 9'(a * 3 + 3), 9'(a + 4)};
  endfunction

  task automatic chk(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one sampled edge; inputs set now, returns 1 ns after the edge
  task automatic cyc(bit p, bit c, bit st, logic [AW-1:0] a, bit sa, bit sbn,
                     bit scc, bit gw, bit be, logic [LN-1:0] ls,
                     logic [WW-1:0] d, bit keep, string tag);
    bit chip, rd, wr;
    logic [LN-1:0] mask;
    logic [AW-1:0] t;
    p_n = p; c_n = c; st_n = st; addr = a; sa_n = sa; sb_n = sbn; sc = scc;
    gw_n = gw; be_n = be; ls_n = ls; wdata = d;
    chip = !sa && !sbn && scc;
    mask = !gw ? '1 : (!be ? ~ls : '0);
    rd = 0; wr = 0;
    if (!p && !sa) begin
      if (chip) begin m_live = 1; m_base = a; m_cnt = 0; rd = 1; end
      else m_live = 0;
    end else if (!c) begin
      if (chip) begin
        m_live = 1; m_base = a; m_cnt = 0;
        if (|mask) wr = 1; else rd = 1;
      end else m_live = 0;
    end else if (m_live) begin
      if (!st) m_cnt = (m_cnt + 1) % 4;
      if (|mask) wr = 1; else rd = 1;
    end
    t = m_addr();
    if (wr)
      for (int i = 0; i < LN; i++)
        if (mask[i]) rmem[t][i*LW +: LW] = d[i*LW +: LW];
    if (rd && keep) exp_q.push_back('{rmem[t], tag});
    @(posedge clk);
    #1;
  endtask

  task automatic idle();            // deselect: select A high, controller strobe low
    cyc(1, 0, 1, '0, 1, 0, 1, 1, 1, '1, '0, 0, "");
  endtask
  task automatic prd(logic [AW-1:0] a, bit keep, bit gw, string tag);
    cyc(0, 1, 1, a, 0, 0, 1, gw, 1, '1, 36'hABCDE1234, keep, tag);
  endtask
  task automatic crd(logic [AW-1:0] a, string tag);
    cyc(1, 0, 1, a, 0, 0, 1, 1, 1, '1, '0, 1, tag);
  endtask
  task automatic cwr(logic [AW-1:0] a, bit gw, bit be, logic [LN-1:0] ls,
                     logic [WW-1:0] d, string tag);
    cyc(1, 0, 1, a, 0, 0, 1, gw, be, ls, d, 1, tag);
  endtask
  task automatic cont(bit st, bit gw, bit be, logic [LN-1:0] ls,
                      logic [WW-1:0] d, bit keep, string tag);
    cyc(1, 1, st, '0, 0, 0, 1, gw, be, ls, d, keep, tag);
  endtask

  // scoreboard monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done && rdata_oe) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected word actual=%h expected=none", rdata);
      end else begin
        exp_t e;
        bit ok;
        e = exp_q.pop_front();
        ok = 1;
        for (int i = 0; i < LN; i++)
          if (rdata[i*LW +: LW] !== e.v[i*LW +: LW]) ok = 0;
        if (!ok) begin
          bad++;
          $display("FAIL %s read actual=%h expected=%h", e.tag, rdata, e.v);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) rmem[i] = 'x;
    // reset held for three edges
    idle(); idle(); idle();
    chk("R11", {35'd0, rdata_oe}, 36'd0);
    chk("R11", rdata, '0);
    rst_n = 1'b1;
    m_live = 0;
    // R11: continue/suspend with write strobes before any start: no effect
    cont(0, 0, 1, '1, 36'hFFFFFFFFF, 1, "R11");
    cont(1, 0, 1, '1, 36'hFFFFFFFFF, 1, "R11");
    chk("R11", {35'd0, rdata_oe}, 36'd0);

    // fill every word with four-beat write bursts (R4, R5, R6)
    for (int g = 0; g < DEPTH / 4; g++) begin
      cwr(AW'(g * 4), 0, 1, '1, pat(g * 4), "R4");
      for (int b = 1; b < 4; b++) cont(0, 0, 1, '1, pat(g * 4 + b), 1, "R6");
    end
    idle();

    // R8 latency and R9 asynchronous enable
    prd(5, 1, 1, "R8");
    chk("R8", {35'd0, rdata_oe}, 36'd0);
    idle();
    chk("R8", {35'd0, rdata_oe}, 36'd1);
    oe_n = 1'b1; #0.4;
    chk("R9", {35'd0, rdata_oe}, 36'd0);
    chk("R9", rdata, '0);
    oe_n = 1'b0; #0.4;
    chk("R9", {35'd0, rdata_oe}, 36'd1);
    idle();
    chk("R1", {35'd0, rdata_oe}, 36'd0);

    // R1: each bad select combination on a strobe is a deselect
    crd(7, "R1");
    cyc(1, 0, 1, '0, 0, 1, 1, 1, 1, '1, '0, 0, "");
    cyc(1, 0, 1, '0, 0, 1, 1, 1, 1, '1, '0, 0, "");
    chk("R1", {35'd0, rdata_oe}, 36'd0);
    crd(8, "R1");
    cyc(1, 0, 1, '0, 0, 0, 0, 1, 1, '1, '0, 0, "");
    cyc(0, 1, 1, '0, 0, 0, 0, 1, 1, '1, '0, 0, "");
    chk("R1", {35'd0, rdata_oe}, 36'd0);
    // burst is over: a continue cycle now reads nothing
    cont(0, 1, 1, '1, '0, 1, "R1");
    cont(0, 1, 1, '1, '0, 1, "R1");
    chk("R1", {35'd0, rdata_oe}, 36'd0);

    // R2: processor strobe ignored while select A is high
    prd(9, 1, 1, "R2");
    cyc(0, 1, 0, '0, 1, 0, 1, 1, 1, '1, '0, 1, "R2");
    cyc(1, 0, 1, '0, 1, 0, 1, 1, 1, '1, '0, 0, "");
    cyc(1, 0, 1, '0, 1, 0, 1, 1, 1, '1, '0, 0, "");
    chk("R2", {35'd0, rdata_oe}, 36'd0);

    // R3: processor strobe ignores write inputs; R10: write after read blanks output
    prd(12, 0, 0, "R3");
    cont(1, 1, 0, 4'b1110, 36'h1FF1FF1FF, 1, "R7");
    chk("R10", {35'd0, rdata_oe}, 36'd0);
    idle();
    chk("R10", {35'd0, rdata_oe}, 36'd0);
    crd(12, "R3");
    idle(); idle();

    // R5: lane masks
    cwr(20, 1, 0, 4'b1010, 36'h123456789, "R5");
    idle();
    crd(20, "R5");
    cwr(21, 1, 1, 4'b0000, 36'h0F0F0F0F0, "R5");
    idle();
    cwr(22, 0, 1, 4'b1111, 36'h987654321, "R5");
    idle();
    crd(22, "R5");
    cwr(23, 1, 0, 4'b1111, 36'h555555555, "R5");
    idle();
    crd(23, "R5");
    idle();

    // R6 linear order from an odd start, with wrap
    lin = 1'b1;
    crd(33, "R6");
    for (int b = 0; b < 4; b++) cont(0, 1, 1, '1, '0, 1, "R6");
    idle();
    // R6 interleaved order
    lin = 1'b0;
    crd(46, "R6");
    for (int b = 0; b < 4; b++) cont(0, 1, 1, '1, '0, 1, "R6");
    idle();
    cwr(51, 0, 1, '1, 36'h0AA0BB0CC, "R6");
    for (int b = 1; b < 4; b++) cont(0, 0, 1, '1, 36'h011022033 + 36'(b), 1, "R6");
    idle();
    crd(48, "R6");
    for (int b = 1; b < 4; b++) cont(0, 1, 1, '1, '0, 1, "R6");
    idle();

    // R7 suspend repeats the address
    crd(40, "R7");
    cont(1, 1, 1, '1, '0, 1, "R7");
    cont(1, 1, 1, '1, '0, 1, "R7");
    cont(0, 1, 1, '1, '0, 1, "R7");
    idle();

    // R10 output stays off after a write
    cwr(60, 0, 1, '1, 36'h3C3C3C3C3, "R10");
    chk("R10", {35'd0, rdata_oe}, 36'd0);
    idle();
    chk("R10", {35'd0, rdata_oe}, 36'd0);
    crd(60, "R10");
    idle(); idle(); idle();

    chk("R8", 36'(exp_q.size()), 36'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule